// File: doc/BRIEF.md
# Quasi-Bidirectional Port Drive Controller

This block is the digital side of three 8-bit quasi-bidirectional I/O ports on a small microcontroller. It holds one output latch per port and an I/O control register. Both are reached over a simple special-function-register (SFR) bus. For every pin it drives three separate enables: a low-side pull-down, a strong pull-up and a weak pull-up. The pad cell turns these enables into drive current.

The pin inputs are synchronized before use. The synchronized level serves two purposes: pin reads, and the adaptive strong pull-up. The strong pull-up is dropped once a pin is sensed low, which lets a weak external driver hold the pin at 0. It returns once the pin is sensed high again. Per-port control bits take the whole output driver off a port and leave it as a plain high-impedance input. One global control bit forces weak-only pull-up on every pin.

Top module: `qbport_ctrl`

## Requirements
- R1: Reset (active-low `rstN`, asynchronous) behaves as follows:
  - every port latch becomes 0xFF and the control register becomes 0;
  - the pin synchronizers start at 1;
  - every pin therefore has weak and strong pull-up on and pull-down off.
- R2: A write with `sfrWrEn`=1 to a port address changes that port's latch in the next cycle. Port 1 is at 0x90, port 2 at 0xA0 and port 3 at 0xB0. Pin bit i of port n is bit 8*(n-1)+i of the pin vectors. A pin whose latch bit is 0 has pull-down on and both pull-ups off.
- R3: In normal mode, a pin whose latch bit is 1 has pull-down off and weak pull-up on. Its strong pull-up is on only while its synchronized level is 1.
- R4: The control register sits at 0xF8. Setting its bit 1, 2 or 3 puts port 1, 2 or 3 into high-impedance mode. In that mode all three enables of every pin of that port are off. Other ports are unaffected.
- R5: A port in high-impedance mode still accepts latch writes. Its pins still read back their synchronized levels.
- R6: The strong pull-up on a pin goes off when a 1-to-0 change of `pinIn` reaches the output of the two-flop synchronizer. That happens at the second rising edge after the change. The weak pull-up stays on.
- R7: The strong pull-up comes back on when a 0-to-1 change of the pin reaches the synchronizer output. That also happens at the second rising edge after the change.
- R8: Setting bit 4 of the control register keeps every strong pull-up off, whatever the pin levels. Weak pull-ups and pull-downs are unchanged.
- R9: A read of 0xF8 returns control bits 4..1 in place, with all other bits 0. Written values for bits 0, 5, 6 and 7 are discarded.
- R10: Reads are combinational from `sfrAddr`:
  - a read of a port address with `sfrRdLatch`=1 returns the latch;
  - a read of a port address with `sfrRdLatch`=0 returns the synchronized pin levels;
  - any other address reads 0.
- R11: A control-register write changes the drive enables in the cycle after the write and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sfrAddr | input | 8 | SFR address for read and write |
| sfrWrEn | input | 1 | Write strobe |
| sfrWrData | input | 8 | Write data |
| sfrRdLatch | input | 1 | Port read selects latch (1) or pin level (0) |
| sfrRdData | output | 8 | Read data |
| pinIn | input | 24 | Sensed pin levels, port 1 in bits 7:0 |
| pullDown | output | 24 | Low-side driver enable per pin |
| weakUp | output | 24 | Weak pull-up enable per pin |
| strongUp | output | 24 | Strong pull-up enable per pin |

## Verification
Two functions can act on the same pin in the same cycle. The first is the adaptive strong pull-up, which reacts to the synchronized pin level. The second is the control path, where a high-impedance or weak-only write overrides that pull-up. The bench provokes the overlap by driving a pin low while its port is in high-impedance mode and then leaving that mode. The strong pull-up must come back only where both the latch bit and the sensed level are 1. It also rewrites a latch while the port is in high-impedance mode. There it judges three things: the enables stay off, the latch readback shows the new value, and the pin readback still follows the pin.

// File: rtl/qbport_pkg.sv
package qbport_pkg;
  localparam int NUM_PORTS = 3;
  localparam int PORT_W = 8;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;
  localparam int PIN_COUNT = NUM_PORTS * PORT_W;
  localparam int SYNC_STAGES = 2;

  localparam logic [ADDR_W-1:0] CTRL_ADDR = 8'hF8;
  localparam logic [ADDR_W-1:0] PORT_BASE = 8'h90;
  localparam int PORT_STRIDE = 16;

  localparam int HZ_LSB = 1;
  localparam int WEAK_ONLY_BIT = HZ_LSB + NUM_PORTS;
  localparam logic [DATA_W-1:0] CTRL_MASK =
    DATA_W'(((1 << (NUM_PORTS + 1)) - 1) << HZ_LSB);

  function automatic logic [ADDR_W-1:0] portAddr(input int idx);
    return PORT_BASE + ADDR_W'(idx * PORT_STRIDE);
  endfunction

  typedef struct packed {
    logic [NUM_PORTS-1:0] latchWr;
    logic                 ctrlWr;
    logic [NUM_PORTS-1:0] portSel;
    logic                 ctrlSel;
    logic                 useLatch;
  } strobes_t;
endpackage

// File: rtl/qbport_control.sv
module qbport_control
  import qbport_pkg::*;
(
  input  logic [ADDR_W-1:0] sfrAddr,
  input  logic              sfrWrEn,
  input  logic              sfrRdLatch,
  output strobes_t          strb
);
  logic [NUM_PORTS-1:0] hitPort;
  logic hitCtrl;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : gDecode
    assign hitPort[p] = (sfrAddr == portAddr(p));
  end

  assign hitCtrl = (sfrAddr == CTRL_ADDR);

  always_comb begin
    strb.latchWr  = hitPort & {NUM_PORTS{sfrWrEn}};
    strb.ctrlWr   = hitCtrl & sfrWrEn;
    strb.portSel  = hitPort;
    strb.ctrlSel  = hitCtrl;
    strb.useLatch = sfrRdLatch;
  end
endmodule

// File: rtl/qbport_datapath.sv
module qbport_datapath
  import qbport_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  strobes_t             strb,
  input  logic [DATA_W-1:0]    wrData,
  input  logic [PIN_COUNT-1:0] pinIn,
  output logic [DATA_W-1:0]    rdData,
  output logic [PIN_COUNT-1:0] pullDown,
  output logic [PIN_COUNT-1:0] weakUp,
  output logic [PIN_COUNT-1:0] strongUp
);
  logic [NUM_PORTS-1:0][PORT_W-1:0] latchQ;
  logic [DATA_W-1:0] ctrlQ;
  logic [SYNC_STAGES-1:0][PIN_COUNT-1:0] syncQ;
  logic [PIN_COUNT-1:0] pinLevel;
  logic weakOnly;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int p = 0; p < NUM_PORTS; p++) latchQ[p] <= '1;
      ctrlQ <= '0;
    end else begin
      for (int p = 0; p < NUM_PORTS; p++)
        if (strb.latchWr[p]) latchQ[p] <= wrData[PORT_W-1:0];
      if (strb.ctrlWr) ctrlQ <= wrData & CTRL_MASK;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '1;
    end else begin
      syncQ[0] <= pinIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
    end
  end

  assign pinLevel = syncQ[SYNC_STAGES-1];
  assign weakOnly = ctrlQ[WEAK_ONLY_BIT];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : gPort
    logic hiZ;
    assign hiZ = ctrlQ[HZ_LSB + p];
    for (genvar b = 0; b < PORT_W; b++) begin : gPin
      localparam int IDX = p * PORT_W + b;
      assign pullDown[IDX] = !hiZ && !latchQ[p][b];
      assign weakUp[IDX]   = !hiZ && latchQ[p][b];
      assign strongUp[IDX] = !hiZ && latchQ[p][b] && !weakOnly && pinLevel[IDX];
    end
  end

  always_comb begin
    rdData = '0;
    if (strb.ctrlSel) rdData = ctrlQ & CTRL_MASK;
    for (int p = 0; p < NUM_PORTS; p++)
      if (strb.portSel[p])
        rdData = strb.useLatch ? latchQ[p] : pinLevel[p*PORT_W +: PORT_W];
  end
endmodule

// File: rtl/qbport_ctrl.sv
module qbport_ctrl
  import qbport_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    sfrAddr,
  input  logic                 sfrWrEn,
  input  logic [DATA_W-1:0]    sfrWrData,
  input  logic                 sfrRdLatch,
  output logic [DATA_W-1:0]    sfrRdData,
  input  logic [PIN_COUNT-1:0] pinIn,
  output logic [PIN_COUNT-1:0] pullDown,
  output logic [PIN_COUNT-1:0] weakUp,
  output logic [PIN_COUNT-1:0] strongUp
);
  strobes_t strb;

  qbport_control u_control (
    .sfrAddr(sfrAddr), .sfrWrEn(sfrWrEn), .sfrRdLatch(sfrRdLatch), .strb(strb)
  );

  qbport_datapath u_datapath (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(sfrWrData), .pinIn(pinIn),
    .rdData(sfrRdData), .pullDown(pullDown), .weakUp(weakUp), .strongUp(strongUp)
  );
endmodule

// File: rtl/qbport_ctrl_chk.sv
module qbport_ctrl_chk
  import qbport_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic [ADDR_W-1:0]    sfrAddr,
  input logic                 sfrWrEn,
  input logic [DATA_W-1:0]    sfrWrData,
  input logic [DATA_W-1:0]    sfrRdData,
  input logic [PIN_COUNT-1:0] pinIn,
  input logic [PIN_COUNT-1:0] pullDown,
  input logic [PIN_COUNT-1:0] weakUp,
  input logic [PIN_COUNT-1:0] strongUp
);
  logic [1:0] warm;
  logic ctrlWrite;
  logic [DATA_W-1:0] ctrlVal;
  logic [PIN_COUNT-1:0] anyDrive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) warm <= '0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  assign ctrlWrite = sfrWrEn && (sfrAddr == CTRL_ADDR);
  assign ctrlVal   = sfrWrData & CTRL_MASK;
  assign anyDrive  = pullDown | weakUp | strongUp;

  assert_drive_exclusive_R2: assert property (@(posedge clk) disable iff (!rstN)
    (pullDown & (weakUp | strongUp)) == '0);

  assert_strong_needs_weak_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strongUp & ~weakUp) == '0);

  assert_weak_only_R8: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWrite && ctrlVal[WEAK_ONLY_BIT] |=> strongUp == '0);

  assert_ctrl_read_R9: assert property (@(posedge clk) disable iff (!rstN)
    sfrAddr == CTRL_ADDR |-> (sfrRdData & ~CTRL_MASK) == '0);

  assert_strong_drop_R6: assert property (@(posedge clk) disable iff (!rstN)
    warm == 2'd3 |-> (~pinIn & ~$past(pinIn) & ~$past(pinIn, 2) & strongUp) == '0);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : gHz
    assert_hz_port_R4: assert property (@(posedge clk) disable iff (!rstN)
      ctrlWrite && ctrlVal[HZ_LSB + p] |=> anyDrive[p*PORT_W +: PORT_W] == '0);
  end
endmodule

bind qbport_ctrl qbport_ctrl_chk u_chk (.*);

// File: tb/tb_qbport_ctrl.sv
`timescale 1ns/100ps
module tb_qbport_ctrl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] sfrAddr = 8'h00;
  logic sfrWrEn = 1'b0;
  logic [7:0] sfrWrData = 8'h00;
  logic sfrRdLatch = 1'b1;
  logic [7:0] sfrRdData;
  logic [23:0] pinIn = 24'hFFFFFF;
  logic [23:0] pullDown, weakUp, strongUp;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  qbport_ctrl dut (.*);

  typedef struct packed {
    logic [7:0] a; logic [7:0] d;
    logic [23:0] pd; logic [23:0] wk; logic [23:0] st;
    logic [7:0] rd;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    {8'h90, 8'hA5, 24'h00005A, 24'hFFFFA5, 24'hFFFFA5, 8'hA5},
    {8'hA0, 8'h0F, 24'h00F05A, 24'hFF0FA5, 24'hFF0FA5, 8'h0F},
    {8'hF8, 8'h04, 24'h00005A, 24'hFF00A5, 24'hFF00A5, 8'h04},
    {8'hA0, 8'h3C, 24'h00005A, 24'hFF00A5, 24'hFF00A5, 8'h3C},
    {8'hF8, 8'h10, 24'h00C35A, 24'hFF3CA5, 24'h000000, 8'h10},
    {8'hF8, 8'h0E, 24'h000000, 24'h000000, 24'h000000, 8'h0E},
    {8'hF8, 8'h00, 24'h00C35A, 24'hFF3CA5, 24'hFF3CA5, 8'h00},
    {8'hB0, 8'h00, 24'hFFC35A, 24'h003CA5, 24'h003CA5, 8'h00},
    {8'hF8, 8'hE1, 24'hFFC35A, 24'h003CA5, 24'h003CA5, 8'h00}
  };

  task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic sfrWrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    sfrAddr = a; sfrWrData = d; sfrWrEn = 1'b1;
    @(negedge clk);
    sfrWrEn = 1'b0;
  endtask

  task automatic sfrRead(input logic [7:0] a, input logic latchSel, output logic [7:0] d);
    sfrAddr = a; sfrRdLatch = latchSel;
    #0.5;
    d = sfrRdData;
  endtask

  task automatic drives(input string tag, input logic [23:0] pd, input logic [23:0] wk,
                        input logic [23:0] st);
    check({tag, " pullDown"}, pullDown, pd);
    check({tag, " weakUp"}, weakUp, wk);
    check({tag, " strongUp"}, strongUp, st);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    drives("R1 reset", 24'h000000, 24'hFFFFFF, 24'hFFFFFF);
    sfrRead(8'hF8, 1'b1, rd); check("R1 ctrl after reset", 24'(rd), 24'h00);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    sfrRead(8'hB0, 1'b1, rd); check("R1 latch after reset", 24'(rd), 24'hFF);

    // R2 R3 R4 R5 R8 R9: vector walk with all pins high
    for (int i = 0; i < NV; i++) begin
      sfrWrite(VEC[i].a, VEC[i].d);
      drives($sformatf("R2/R3/R4/R8 vec%0d", i), VEC[i].pd, VEC[i].wk, VEC[i].st);
      sfrRead(VEC[i].a, 1'b1, rd);
      check($sformatf("R5/R9 read vec%0d", i), 24'(rd), 24'(VEC[i].rd));
    end

    sfrWrite(8'hB0, 8'hFF);
    drives("R2 restore", 24'h00C35A, 24'hFF3CA5, 24'hFF3CA5);

    // R6: pin 0 falls, strong pull-up drops after two edges
    @(negedge clk); pinIn = 24'hFFFFFE;
    @(negedge clk);
    check("R6 one edge strong", strongUp, 24'hFF3CA5);
    @(negedge clk);
    drives("R6 two edges", 24'h00C35A, 24'hFF3CA5, 24'hFF3CA4);
    sfrRead(8'h90, 1'b0, rd); check("R10 pin read", 24'(rd), 24'hFE);
    sfrRead(8'h90, 1'b1, rd); check("R10 latch read", 24'(rd), 24'hA5);

    // R7: pin 0 rises
    pinIn = 24'hFFFFFF;
    @(negedge clk);
    check("R7 one edge strong", strongUp, 24'hFF3CA4);
    @(negedge clk);
    check("R7 two edges strong", strongUp, 24'hFF3CA5);

    // R5 with R6: port 1 high-impedance, latch write and pin read
    sfrWrite(8'hF8, 8'h02);
    drives("R4 port1 hz", 24'h00C300, 24'hFF3C00, 24'hFF3C00);
    pinIn = 24'hFFFF3C;
    repeat (2) @(negedge clk);
    sfrRead(8'h90, 1'b0, rd); check("R5 hz pin read", 24'(rd), 24'h3C);
    sfrWrite(8'h90, 8'h11);
    sfrRead(8'h90, 1'b1, rd); check("R5 hz latch write", 24'(rd), 24'h11);
    drives("R5 hz drive off", 24'h00C300, 24'hFF3C00, 24'hFF3C00);
    sfrWrite(8'hF8, 8'h00);
    drives("R6 leave hz", 24'h00C3EE, 24'hFF3C11, 24'hFF3C10);

    // R11: control write effect timing
    pinIn = 24'hFFFFFF;
    repeat (2) @(negedge clk);
    sfrAddr = 8'hF8; sfrWrData = 8'h10; sfrWrEn = 1'b1;
    #0.5;
    check("R11 before edge", strongUp, 24'hFF3C11);
    @(negedge clk); sfrWrEn = 1'b0;
    check("R11 after edge", strongUp, 24'h000000);
    check("R8 weak kept", weakUp, 24'hFF3C11);

    sfrRead(8'h55, 1'b1, rd); check("R10 unmapped latch sel", 24'(rd), 24'h00);
    sfrRead(8'h55, 1'b0, rd); check("R10 unmapped pin sel", 24'(rd), 24'h00);

    // R1: reset in mid-run
    @(negedge clk); rstN = 1'b0;
    #0.5;
    drives("R1 mid reset", 24'h000000, 24'hFFFFFF, 24'hFFFFFF);
    sfrRead(8'hF8, 1'b1, rd); check("R1 mid reset ctrl", 24'(rd), 24'h00);
    sfrRead(8'h90, 1'b1, rd); check("R1 mid reset latch", 24'(rd), 24'hFF);
    @(negedge clk); rstN = 1'b1;
    repeat (2) @(negedge clk);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule